// File: doc/BRIEF.md
# Hot-Plug Slot Event Collector

This block keeps one 32-bit status/control word for each hot-plug slot and funnels slot activity into a single interrupt locator. Every cycle it samples each slot's raw signals: a two-bit presence code, an isolated power-fault flag, a connected power-fault flag, the attention-button level and the retention-latch level. Any change that counts as an event sets a sticky event bit. Software acknowledges an event by writing a 1 to that bit. Each event has its own interrupt mask bit. Latch change and connected power fault also carry an error-report mask, which is stored here and acted on elsewhere.

The locator word gives a pending bit for each slot, shifted up by one position. Bit 0 is left free for a command-complete indication, which comes from a small controller word. That word holds a global interrupt mask, a command-complete mask and a sticky command-complete flag. The interrupt line is the OR of all locator bits, and the global mask can silence it while the locator stays readable.

The bus-side decoder is outside this block. It presents one write strobe per slot word, one strobe for the controller word and a shared 32-bit write data bus. It reads the words from the flat outputs.

Top module: `hp_event_hub`

## Requirements
- R1: After reset every slot word has all event bits clear and all mask bits 30:24 set. The controller word reads 0x5 (global mask bit 0 and command mask bit 2 set, command flag bit 16 clear). The locator reads 0 and the interrupt is low.
- R2: Each slot word shows its sampled inputs one clock after they change. Bit 6 is power good, active low for a fault: it reads 0 when either fault input is high. Bit 7 is the button level. Bit 8 is the latch level (1 = open). Bits 11:10 hold the presence code, where 3 = empty.
- R3: Each event bit is set one clock after its cause:
  - bit 16: any change of the presence code;
  - bit 17: a rising isolated fault;
  - bit 18: a rising button;
  - bit 19: any change of the latch;
  - bit 20: a rising connected fault.
  Falling edges of a fault or of the button set nothing.
- R4: An event bit stays set until it is cleared, and writing 0 to it has no effect.
- R5: Writing 1 to any of bits 20:16 clears that event bit, provided no new event for that bit arrives in the same cycle.
- R6: Bits 28:24 are the interrupt masks for events 16..20, in the same order. Bit 29 is the error-report mask for latch change and bit 30 for connected fault. All seven bits read back as written.
- R7: Bit 15, bits 23:21, bit 31 and every bit not named in R2, R3 or R6 read 0 and ignore writes. The status bits of R2 also ignore writes.
- R8: Locator bit i+1 is 1 exactly when slot i has an event bit set whose interrupt mask is clear. Events that are masked never show.
- R9: A cmd_done pulse sets controller bit 16. Writing 1 to bit 16 clears it. Locator bit 0 is that flag gated by a clear command mask (controller bit 2).
- R10: While controller bit 0 is set, the interrupt output stays low, and the locator still shows pending bits.
- R11: While controller bit 0 is clear, the interrupt output is high whenever any locator bit is 1.
- R12: When a new event and a write-1 clear of the same bit fall in the same cycle, the bit stays set. This applies to slot events and to the command flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_prs | input | 2*NUM_SLOTS | Raw presence code per slot |
| slot_iso_flt | input | NUM_SLOTS | Raw isolated power fault per slot (1 = fault) |
| slot_con_flt | input | NUM_SLOTS | Raw connected power fault per slot (1 = fault) |
| slot_btn | input | NUM_SLOTS | Raw attention-button level per slot |
| slot_latch | input | NUM_SLOTS | Raw latch level per slot (1 = open) |
| slot_wr | input | NUM_SLOTS | Write strobe per slot word |
| ctrl_wr | input | 1 | Write strobe for the controller word |
| wr_data | input | 32 | Shared write data |
| cmd_done | input | 1 | Command-complete pulse |
| slot_regs | output | 32*NUM_SLOTS | Slot words, slot i at bits 32i+31:32i |
| ctrl_reg | output | 32 | Controller word |
| locator | output | NUM_SLOTS+1 | Interrupt locator |
| irq | output | 1 | Interrupt output |

## Verification
A lost or stale event bit appears in the slot word and in its locator bit on the clock after the stimulus. The bench reads both there, so a dropped edge or a clear applied one cycle late is seen at once. A mask bit that is stored wrong shows up in two places: the readback value and a locator bit that is set or missing while the event bit is unchanged. A wrong order between clear and set appears only when the two arrive in the same cycle, so the bench drives that collision directly for a slot event and for the command flag.

// File: rtl/hp_evt_pkg.sv
`timescale 1ns/1ps
package hp_evt_pkg;
    localparam int NUM_EV    = 5;
    localparam int EV_LSB    = 16;
    localparam int IMASK_LSB = 24;
    localparam int SMASK_LSB = 29;
    localparam int SMASK_W   = 2;
    localparam int MASK_W    = NUM_EV + SMASK_W;
    localparam int PWROK_BIT = 6;
    localparam int BTN_BIT   = 7;
    localparam int LATCH_BIT = 8;
    localparam int PRS_LSB   = 10;
    localparam logic [1:0] PRS_EMPTY = 2'b11;

    // event index inside the five-bit event field
    localparam int EV_PRS   = 0;
    localparam int EV_ISO   = 1;
    localparam int EV_BTN   = 2;
    localparam int EV_LATCH = 3;
    localparam int EV_CON   = 4;

    localparam int CTL_GMASK_BIT = 0;
    localparam int CTL_CMASK_BIT = 2;
    localparam int CTL_CDET_BIT  = 16;

    typedef struct packed {
        logic [1:0]         prs;
        logic               iso;
        logic               con;
        logic               btn;
        logic               latch;
        logic [NUM_EV-1:0]  ev;
        logic [NUM_EV-1:0]  imask;
        logic [SMASK_W-1:0] smask;
    } slot_st_t;

    typedef struct packed {
        logic gmask;
        logic cmask;
        logic cdet;
    } ctl_st_t;
endpackage

// File: rtl/hp_slot_reg.sv
`timescale 1ns/1ps
module hp_slot_reg
    import hp_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        prs_raw,
    input  logic              iso_raw,
    input  logic              con_raw,
    input  logic              btn_raw,
    input  logic              latch_raw,
    input  logic              wr_en,
    input  logic [NUM_EV-1:0] wr_clr,
    input  logic [MASK_W-1:0] wr_masks,
    output logic [31:0]       reg_val,
    output logic              pending
);
    slot_st_t          st_d, st_q;
    logic [NUM_EV-1:0] edge_v;
    logic [NUM_EV-1:0] clr_v;

    always_comb begin
        edge_v           = '0;
        edge_v[EV_PRS]   = (prs_raw != st_q.prs);
        edge_v[EV_ISO]   = iso_raw & ~st_q.iso;
        edge_v[EV_BTN]   = btn_raw & ~st_q.btn;
        edge_v[EV_LATCH] = latch_raw ^ st_q.latch;
        edge_v[EV_CON]   = con_raw & ~st_q.con;

        clr_v = wr_en ? wr_clr : '0;

        st_d       = st_q;
        st_d.prs   = prs_raw;
        st_d.iso   = iso_raw;
        st_d.con   = con_raw;
        st_d.btn   = btn_raw;
        st_d.latch = latch_raw;
        st_d.ev    = (st_q.ev & ~clr_v) | edge_v;
        if (wr_en) begin
            {st_d.smask, st_d.imask} = wr_masks;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prs   <= PRS_EMPTY;
            st_q.iso   <= 1'b0;
            st_q.con   <= 1'b0;
            st_q.btn   <= 1'b0;
            st_q.latch <= 1'b0;
            st_q.ev    <= '0;
            st_q.imask <= '1;
            st_q.smask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_val                                = '0;
        reg_val[PWROK_BIT]                     = ~(st_q.iso | st_q.con);
        reg_val[BTN_BIT]                       = st_q.btn;
        reg_val[LATCH_BIT]                     = st_q.latch;
        reg_val[PRS_LSB +: 2]                  = st_q.prs;
        reg_val[EV_LSB +: NUM_EV]              = st_q.ev;
        reg_val[IMASK_LSB +: NUM_EV]           = st_q.imask;
        reg_val[SMASK_LSB +: SMASK_W]          = st_q.smask;
    end

    assign pending = |(st_q.ev & ~st_q.imask);

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((st_q.ev & $past(st_q.ev)) == $past(st_q.ev)));

    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((st_q.ev & $past(wr_clr) & ~$past(edge_v)) == '0));

    // R12
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_v) |=> ((st_q.ev & $past(edge_v)) == $past(edge_v)));
endmodule

// File: rtl/hp_locator.sv
`timescale 1ns/1ps
module hp_locator
    import hp_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int LOC_W    = NUM_SLOTS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_pend,
    input  logic                 cmd_done,
    input  logic                 ctrl_wr,
    input  logic                 gmask_w,
    input  logic                 cmask_w,
    input  logic                 cdet_clr_w,
    output logic [31:0]          ctrl_val,
    output logic [LOC_W-1:0]     loc,
    output logic                 irq_o
);
    ctl_st_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_wr) begin
            ctl_d.gmask = gmask_w;
            ctl_d.cmask = cmask_w;
            if (cdet_clr_w) ctl_d.cdet = 1'b0;
        end
        if (cmd_done) ctl_d.cdet = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.gmask <= 1'b1;
            ctl_q.cmask <= 1'b1;
            ctl_q.cdet  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        loc      = {slot_pend, ctl_q.cdet & ~ctl_q.cmask};
        irq_o    = ~ctl_q.gmask & (|loc);
        ctrl_val = '0;
        ctrl_val[CTL_GMASK_BIT] = ctl_q.gmask;
        ctrl_val[CTL_CMASK_BIT] = ctl_q.cmask;
        ctrl_val[CTL_CDET_BIT]  = ctl_q.cdet;
    end

    // R10
    gmask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.gmask |-> !irq_o);

    // R9
    cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> ctl_q.cdet);

    // R11
    cmd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !ctl_d.cmask && !ctl_d.gmask) |=> irq_o);
endmodule

// File: rtl/hp_event_hub.sv
`timescale 1ns/1ps
module hp_event_hub
    import hp_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int LOC_W    = NUM_SLOTS + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*NUM_SLOTS-1:0]  slot_prs,
    input  logic [NUM_SLOTS-1:0]    slot_iso_flt,
    input  logic [NUM_SLOTS-1:0]    slot_con_flt,
    input  logic [NUM_SLOTS-1:0]    slot_btn,
    input  logic [NUM_SLOTS-1:0]    slot_latch,
    input  logic [NUM_SLOTS-1:0]    slot_wr,
    input  logic                    ctrl_wr,
    input  logic [31:0]             wr_data,
    input  logic                    cmd_done,
    output logic [32*NUM_SLOTS-1:0] slot_regs,
    output logic [31:0]             ctrl_reg,
    output logic [LOC_W-1:0]        locator,
    output logic                    irq
);
    logic [NUM_SLOTS-1:0] pend;
    logic                 unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[31], wr_data[23:21], wr_data[15:3], wr_data[1]};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        hp_slot_reg i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .prs_raw  (slot_prs[2*s +: 2]),
            .iso_raw  (slot_iso_flt[s]),
            .con_raw  (slot_con_flt[s]),
            .btn_raw  (slot_btn[s]),
            .latch_raw(slot_latch[s]),
            .wr_en    (slot_wr[s]),
            .wr_clr   (wr_data[EV_LSB +: NUM_EV]),
            .wr_masks (wr_data[IMASK_LSB +: MASK_W]),
            .reg_val  (slot_regs[32*s +: 32]),
            .pending  (pend[s])
        );
    end

    hp_locator #(.NUM_SLOTS(NUM_SLOTS)) i_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_pend (pend),
        .cmd_done  (cmd_done),
        .ctrl_wr   (ctrl_wr),
        .gmask_w   (wr_data[CTL_GMASK_BIT]),
        .cmask_w   (wr_data[CTL_CMASK_BIT]),
        .cdet_clr_w(wr_data[CTL_CDET_BIT]),
        .ctrl_val  (ctrl_reg),
        .loc       (locator),
        .irq_o     (irq)
    );

    // R8
    loc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((locator[LOC_W-1:1] & ~pend) == '0));
endmodule

// File: tb/test_hp_event_hub.sv
`timescale 1ns/1ps
module test_hp_event_hub;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*N-1:0]  slot_prs = '1;
    logic [N-1:0]    slot_iso_flt = '0;
    logic [N-1:0]    slot_con_flt = '0;
    logic [N-1:0]    slot_btn = '0;
    logic [N-1:0]    slot_latch = '0;
    logic [N-1:0]    slot_wr = '0;
    logic            ctrl_wr = 1'b0;
    logic [31:0]     wr_data = '0;
    logic            cmd_done = 1'b0;
    logic [32*N-1:0] slot_regs;
    logic [31:0]     ctrl_reg;
    logic [N:0]      locator;
    logic            irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hp_event_hub #(.NUM_SLOTS(N)) i_hp_event_hub (
        .clk(clk), .rst_n(rst_n), .slot_prs(slot_prs),
        .slot_iso_flt(slot_iso_flt), .slot_con_flt(slot_con_flt),
        .slot_btn(slot_btn), .slot_latch(slot_latch), .slot_wr(slot_wr),
        .ctrl_wr(ctrl_wr), .wr_data(wr_data), .cmd_done(cmd_done),
        .slot_regs(slot_regs), .ctrl_reg(ctrl_reg), .locator(locator), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sreg(input int s);
        return slot_regs[32*s +: 32];
    endfunction

    task automatic wr_slot(input int s, input logic [31:0] d);
        slot_wr[s] = 1'b1;
        wr_data    = d;
        tick();
        slot_wr    = '0;
        wr_data    = '0;
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        ctrl_wr = 1'b1;
        wr_data = d;
        tick();
        ctrl_wr = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset();
        for (int s = 0; s < N; s++) chk("R1 slot word", sreg(s), 32'h7F00_0C40);
        chk("R1 ctrl word", ctrl_reg, 32'h5);
        chk("R1 locator", 32'(locator), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_status();
        slot_btn[1] = 1'b1; slot_latch[1] = 1'b1; slot_iso_flt[1] = 1'b1;
        slot_prs[3:2] = 2'b00;
        tick();
        chk("R2 R3 status and events", sreg(1), 32'h7F0F_0180);
        chk("R8 masked events hidden", 32'(locator), 32'h0);
        wr_slot(1, 32'h7F1F_0000);
        chk("R5 write-1 clear", sreg(1), 32'h7F00_0180);
        slot_btn[1] = 1'b0; slot_latch[1] = 1'b0; slot_iso_flt[1] = 1'b0;
        slot_prs[3:2] = 2'b11;
        tick();
        chk("R3 falling edges", sreg(1), 32'h7F09_0C40);
        wr_slot(1, 32'h7F1F_0000);
        chk("R5 clear again", sreg(1), 32'h7F00_0C40);
    endtask

    task automatic t_conn();
        slot_con_flt[2] = 1'b1;
        tick();
        chk("R3 connected fault", sreg(2), 32'h7F10_0C00);
        chk("R8 masked", 32'(locator), 32'h0);
        wr_slot(2, 32'h0);
        chk("R4 write 0 keeps event", sreg(2), 32'h0010_0C00);
        chk("R8 unmasked locator", 32'(locator), 32'h08);
        chk("R10 global mask silences", 32'(irq), 32'h0);
        wr_ctrl(32'h0);
        chk("R10 ctrl readback", ctrl_reg, 32'h0);
        chk("R11 irq raised", 32'(irq), 32'h1);
        wr_slot(2, 32'h0010_0000);
        chk("R5 clear held fault", sreg(2), 32'h0000_0C00);
        chk("R11 irq drops", 32'(irq), 32'h0);
        slot_con_flt[2] = 1'b0;
        tick();
        chk("R3 fault release no event", sreg(2), 32'h0000_0C40);
        wr_slot(2, 32'h7F00_0000);
    endtask

    task automatic t_rsvd();
        wr_slot(0, 32'hFFE0_FFFF);
        chk("R7 reserved ignored", sreg(0), 32'h7F00_0C40);
        wr_slot(0, 32'h0A00_0000);
        chk("R6 int mask readback", sreg(0), 32'h0A00_0C40);
        wr_slot(0, 32'h6000_0000);
        chk("R6 error mask readback", sreg(0), 32'h6000_0C40);
        wr_slot(0, 32'h7F00_0000);
    endtask

    task automatic t_cmd();
        cmd_done = 1'b1;
        tick();
        cmd_done = 1'b0;
        chk("R9 flag set", ctrl_reg, 32'h0001_0000);
        chk("R9 locator bit0", 32'(locator), 32'h1);
        chk("R11 irq from command", 32'(irq), 32'h1);
        wr_ctrl(32'h4);
        chk("R9 flag sticky", ctrl_reg, 32'h0001_0004);
        chk("R9 command mask", 32'(locator), 32'h0);
        wr_ctrl(32'h0001_0000);
        chk("R9 flag cleared", ctrl_reg, 32'h0);
    endtask

    task automatic t_race();
        wr_slot(3, 32'h7B00_0000);
        slot_btn[3] = 1'b1;
        slot_wr[3]  = 1'b1;
        wr_data     = 32'h7B04_0000;
        tick();
        slot_wr = '0; wr_data = '0;
        chk("R12 edge beats clear", sreg(3), 32'h7B04_0CC0);
        chk("R8 slot3 locator", 32'(locator), 32'h10);
        wr_slot(3, 32'h7B04_0000);
        chk("R5 clear with button held", sreg(3), 32'h7B00_0CC0);
        slot_btn[3] = 1'b0;
        tick();
        chk("R3 button release no event", sreg(3), 32'h7B00_0C40);
        wr_slot(3, 32'h7F00_0000);
        cmd_done = 1'b1;
        ctrl_wr  = 1'b1;
        wr_data  = 32'h0001_0000;
        tick();
        cmd_done = 1'b0; ctrl_wr = 1'b0; wr_data = '0;
        chk("R12 command set beats clear", ctrl_reg, 32'h0001_0000);
        wr_ctrl(32'h0001_0000);
        chk("R9 command cleared", ctrl_reg, 32'h0);
    endtask

    task automatic t_multi();
        wr_slot(0, 32'h7700_0000);
        wr_slot(1, 32'h7700_0000);
        slot_latch[1:0] = 2'b11;
        tick();
        chk("R8 two slots pending", 32'(locator), 32'h06);
        chk("R11 irq two slots", 32'(irq), 32'h1);
        wr_slot(0, 32'h7708_0000);
        chk("R5 slot0 cleared", sreg(0), 32'h7700_0D40);
        chk("R8 one slot left", 32'(locator), 32'h04);
        wr_ctrl(32'h1);
        chk("R10 locator still readable", 32'(locator), 32'h04);
        chk("R10 irq silenced", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_status();
        t_conn();
        t_rsvd();
        t_cmd();
        t_race();
        t_multi();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule